// File: doc/BRIEF.md
# Multichannel Sub-Frame Serial Shifter

This block moves audio words between a pair of word FIFOs and one serial data line that carries a time-division multichannel frame. A frame holds one or two sub-frames, sent back to back. Each sub-frame has its own channel count, slot length in bits, word length and per-channel enable mask. On the transmit side the block takes 32-bit words from a show-ahead transmit FIFO and sends each one MSB first at the start of an enabled slot. On the receive side it collects the bits of each enabled slot into a right-aligned word and hands it to the receive FIFO.

Timing comes entirely from an external clock generator. That generator supplies three single-cycle strobes for each bit period: start, centre and end. It also flags the first bit of every frame. Bits of the frame beyond the last slot of the last sub-frame are idle. The configuration is expected to stay static while frames run.

Top module: `tdm_subframe_shifter`

## Requirements
- R1: With `twoSub` low a frame holds only sub-frame 0. With it high, sub-frame 1 follows directly after the last slot of sub-frame 0. Bits after the final slot are idle: `sdOut` is 0 and nothing is sampled.
- R2: Each sub-frame carries `chanCnt + 1` channels (field value 0 to 31, giving 1 to 32 channels). The two fields are independent.
- R3: Each sub-frame has its own slot length `slotLen` (7 to 63 bits) and word length `wordLen` (7 to 32 bits, not above the slot length). A transmitted word goes out MSB first, starting at slot bit 0. Slot bits at index `wordLen` and above are 0.
- R4: Bit i of `validMask0`/`validMask1` enables channel i of that sub-frame. A disabled slot pops no transmit word, drives 0 and pushes no receive word.
- R5: A received word occupies bits `wordLen-1:0` of `rxData`, first bit received most significant, upper bits 0. `rxPush` is high for one cycle, in the cycle after the strobe that samples the word's last bit. Slot bits beyond the word length are not sampled.
- R6: `sampleAtEnd` low samples `sdIn` on `bitMid`. High samples it on `bitEnd`.
- R7: `txEn` low keeps `sdOut` at 0 and pops nothing. `rxEn` low produces no `rxPush`. Both high run the two directions at the same time.
- R8: If `txEmpty` is high when an enabled slot begins, the slot sends zeros, nothing is popped, and `txUnderrun` rises and stays high until reset.
- R9: `sdOut` takes the new bit on the clock edge where `bitStart` is high. `txPop` is high in that same cycle, at slot bit 0. `frameStart` together with `bitStart` puts the frame position back at sub-frame 0, channel 0, bit 0.
- R10: During and after reset, `sdOut`, `rxPush`, `txPop` and `txUnderrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStart | input | 1 | Start-of-bit strobe |
| bitMid | input | 1 | Bit-centre strobe |
| bitEnd | input | 1 | End-of-bit strobe |
| frameStart | input | 1 | First bit of a frame, qualified by bitStart |
| twoSub | input | 1 | Frame holds two sub-frames |
| sampleAtEnd | input | 1 | Receive sampling point select |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable |
| chanCnt0 | input | 5 | Sub-frame 0 channel count minus one |
| chanCnt1 | input | 5 | Sub-frame 1 channel count minus one |
| slotLen0 | input | 6 | Sub-frame 0 slot length in bits |
| slotLen1 | input | 6 | Sub-frame 1 slot length in bits |
| wordLen0 | input | 6 | Sub-frame 0 word length in bits |
| wordLen1 | input | 6 | Sub-frame 1 word length in bits |
| validMask0 | input | 32 | Sub-frame 0 channel enables |
| validMask1 | input | 32 | Sub-frame 1 channel enables |
| txData | input | 32 | Head word of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO empty |
| txPop | output | 1 | Consume the head transmit word |
| sdIn | input | 1 | Serial data in |
| sdOut | output | 1 | Serial data out |
| txUnderrun | output | 1 | Sticky transmit underrun |
| rxData | output | 32 | Received word |
| rxPush | output | 1 | rxData valid, one cycle |

## Verification
Suppose the frame position counter slips by a slot or a sub-frame. The serial output then departs from the reference stream at the first bit of the misplaced slot, and the bench compares that output on every clock. A wrong sub-frame selection or channel mask shows up in several ways: a wrong number of FIFO pops, a surplus or missing receive push, or a received word with the wrong length. Each of these is caught within the same frame. Sampling on the wrong strobe gives received words built from the other half of each bit period. The bench drives different values in the two halves, so the first pushed word of such a run is already wrong.

// File: rtl/tdm_shift_pkg.sv
package tdm_shift_pkg;
  parameter int LEN_W = 6;

  typedef struct packed {
    logic             txLoad;
    logic             txShift;
    logic             txIdle;
    logic             txValid;
    logic [LEN_W-1:0] txWordLen;
    logic             rxClear;
    logic             rxSample;
    logic             rxLast;
  } shiftStrobes_t;
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_shift_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int SLOT_W = 6,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStart,
  input  logic              bitMid,
  input  logic              bitEnd,
  input  logic              frameStart,
  input  logic              twoSub,
  input  logic              sampleAtEnd,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic [CH_W-1:0]   chanCnt0,
  input  logic [CH_W-1:0]   chanCnt1,
  input  logic [SLOT_W-1:0] slotLen0,
  input  logic [SLOT_W-1:0] slotLen1,
  input  logic [LEN_W-1:0]  wordLen0,
  input  logic [LEN_W-1:0]  wordLen1,
  input  logic [NUM_CH-1:0] validMask0,
  input  logic [NUM_CH-1:0] validMask1,
  output shiftStrobes_t     strobes
);
  // position of the bit period currently on the line
  logic              curActive, curSub;
  logic [CH_W-1:0]   curChan;
  logic [SLOT_W-1:0] curBit;

  // position that the next bitStart moves to
  logic              nActive, nSub;
  logic [CH_W-1:0]   nChan;
  logic [SLOT_W-1:0] nBit;

  logic [CH_W-1:0]   cCnt;
  logic [SLOT_W-1:0] cSlot;
  logic [LEN_W-1:0]  cWord, nWord;
  logic [NUM_CH-1:0] cMask, nMask;
  logic              txOn, sampleHit, cInWord;

  always_comb begin
    cCnt  = curSub ? chanCnt1   : chanCnt0;
    cSlot = curSub ? slotLen1   : slotLen0;
    cWord = curSub ? wordLen1   : wordLen0;
    cMask = curSub ? validMask1 : validMask0;
  end

  always_comb begin
    nActive = curActive;
    nSub    = curSub;
    nChan   = curChan;
    nBit    = curBit;
    if (frameStart) begin
      nActive = 1'b1;
      nSub    = 1'b0;
      nChan   = '0;
      nBit    = '0;
    end else if (curActive) begin
      if (curBit == cSlot - SLOT_W'(1)) begin
        nBit = '0;
        if (curChan == cCnt) begin
          nChan = '0;
          if (!curSub && twoSub) nSub = 1'b1;
          else                   nActive = 1'b0;
        end else begin
          nChan = curChan + CH_W'(1);
        end
      end else begin
        nBit = curBit + SLOT_W'(1);
      end
    end
    nWord = nSub ? wordLen1   : wordLen0;
    nMask = nSub ? validMask1 : validMask0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curActive <= 1'b0;
      curSub    <= 1'b0;
      curChan   <= '0;
      curBit    <= '0;
    end else if (bitStart) begin
      curActive <= nActive;
      curSub    <= nSub;
      curChan   <= nChan;
      curBit    <= nBit;
    end
  end

  always_comb begin
    txOn      = bitStart && nActive && txEn;
    sampleHit = sampleAtEnd ? bitEnd : bitMid;
    cInWord   = 32'(curBit) < 32'(cWord);

    strobes.txLoad    = txOn && (nBit == '0);
    strobes.txShift   = txOn && (nBit != '0);
    strobes.txIdle    = bitStart && !txOn;
    strobes.txValid   = nMask[nChan];
    strobes.txWordLen = nWord;
    strobes.rxClear   = bitStart && nActive && (nBit == '0);
    strobes.rxSample  = sampleHit && curActive && rxEn && cMask[curChan] && cInWord;
    strobes.rxLast    = strobes.rxSample && (32'(curBit) == 32'(cWord) - 1);
  end

  AST_CHAN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    curActive |-> curChan <= cCnt); // R2
  AST_SLOT_BIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    curActive |-> curBit < cSlot); // R3
  AST_SUB1_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (curActive && curSub) |-> twoSub); // R1
endmodule

// File: rtl/tdm_shift_datapath.sv
module tdm_shift_datapath
  import tdm_shift_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobes_t     strobes,
  input  logic [WORD_W-1:0] txData,
  input  logic              txEmpty,
  input  logic              sdIn,
  output logic              txPop,
  output logic              sdOut,
  output logic              txUnderrun,
  output logic [WORD_W-1:0] rxData,
  output logic              rxPush
);
  logic [WORD_W-1:0] txShreg, aligned, rxAcc, rxNext;
  int                shiftAmt;

  always_comb begin
    shiftAmt = WORD_W - int'(strobes.txWordLen);
    aligned  = txData << shiftAmt;
    txPop    = strobes.txLoad && strobes.txValid && !txEmpty;
    rxNext   = {rxAcc[WORD_W-2:0], sdIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdOut      <= 1'b0;
      txShreg    <= '0;
      txUnderrun <= 1'b0;
    end else if (strobes.txLoad) begin
      if (strobes.txValid && !txEmpty) begin
        sdOut   <= aligned[WORD_W-1];
        txShreg <= aligned << 1;
      end else begin
        sdOut   <= 1'b0;
        txShreg <= '0;
      end
      if (strobes.txValid && txEmpty) txUnderrun <= 1'b1;
    end else if (strobes.txShift) begin
      sdOut   <= txShreg[WORD_W-1];
      txShreg <= txShreg << 1;
    end else if (strobes.txIdle) begin
      sdOut   <= 1'b0;
      txShreg <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxAcc  <= '0;
      rxData <= '0;
      rxPush <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      if (strobes.rxClear) rxAcc <= '0;
      if (strobes.rxSample) begin
        rxAcc <= rxNext;
        if (strobes.rxLast) begin
          rxData <= rxNext;
          rxPush <= 1'b1;
          rxAcc  <= '0;
        end
      end
    end
  end

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty); // R8
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(txUnderrun) |-> txUnderrun); // R8
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rxPush); // R5
endmodule

// File: rtl/tdm_subframe_shifter.sv
module tdm_subframe_shifter
  import tdm_shift_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int WORD_W = 32,
  parameter int SLOT_W = 6,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStart,
  input  logic              bitMid,
  input  logic              bitEnd,
  input  logic              frameStart,
  input  logic              twoSub,
  input  logic              sampleAtEnd,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic [CH_W-1:0]   chanCnt0,
  input  logic [CH_W-1:0]   chanCnt1,
  input  logic [SLOT_W-1:0] slotLen0,
  input  logic [SLOT_W-1:0] slotLen1,
  input  logic [LEN_W-1:0]  wordLen0,
  input  logic [LEN_W-1:0]  wordLen1,
  input  logic [NUM_CH-1:0] validMask0,
  input  logic [NUM_CH-1:0] validMask1,
  input  logic [WORD_W-1:0] txData,
  input  logic              txEmpty,
  output logic              txPop,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              txUnderrun,
  output logic [WORD_W-1:0] rxData,
  output logic              rxPush
);
  shiftStrobes_t strobes;

  tdm_frame_ctrl #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitStart(bitStart), .bitMid(bitMid), .bitEnd(bitEnd),
    .frameStart(frameStart), .twoSub(twoSub), .sampleAtEnd(sampleAtEnd),
    .txEn(txEn), .rxEn(rxEn), .chanCnt0(chanCnt0), .chanCnt1(chanCnt1),
    .slotLen0(slotLen0), .slotLen1(slotLen1), .wordLen0(wordLen0), .wordLen1(wordLen1),
    .validMask0(validMask0), .validMask1(validMask1), .strobes(strobes)
  );

  tdm_shift_datapath #(.WORD_W(WORD_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txData(txData), .txEmpty(txEmpty),
    .sdIn(sdIn), .txPop(txPop), .sdOut(sdOut), .txUnderrun(txUnderrun),
    .rxData(rxData), .rxPush(rxPush)
  );

  AST_TX_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    $past(bitStart && !txEn) |-> !sdOut); // R7
  AST_RX_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !rxPush); // R7
  AST_POP_ON_BIT_START: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> (bitStart && txEn)); // R9
endmodule

// File: tb/sim_tdm_subframe_shifter.sv
`timescale 1ns/1ps
module sim_tdm_subframe_shifter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStart = 0, bitMid = 0, bitEnd = 0, frameStart = 0;
  logic twoSub = 0, sampleAtEnd = 0, txEn = 0, rxEn = 0;
  logic [4:0] chanCnt0 = 0, chanCnt1 = 0;
  logic [5:0] slotLen0 = 8, slotLen1 = 8, wordLen0 = 8, wordLen1 = 8;
  logic [31:0] validMask0 = 0, validMask1 = 0;
  logic [31:0] txData = 0;
  logic txEmpty = 1'b1, sdIn = 1'b0;
  logic txPop, sdOut, txUnderrun, rxPush;
  logic [31:0] rxData;

  always #10 clk = ~clk;

  tdm_subframe_shifter u0 (
    .clk(clk), .rstN(rstN), .bitStart(bitStart), .bitMid(bitMid), .bitEnd(bitEnd),
    .frameStart(frameStart), .twoSub(twoSub), .sampleAtEnd(sampleAtEnd),
    .txEn(txEn), .rxEn(rxEn), .chanCnt0(chanCnt0), .chanCnt1(chanCnt1),
    .slotLen0(slotLen0), .slotLen1(slotLen1), .wordLen0(wordLen0), .wordLen1(wordLen1),
    .validMask0(validMask0), .validMask1(validMask1), .txData(txData), .txEmpty(txEmpty),
    .txPop(txPop), .sdIn(sdIn), .sdOut(sdOut), .txUnderrun(txUnderrun),
    .rxData(rxData), .rxPush(rxPush)
  );

  int checks = 0, errors = 0;
  logic [31:0] fifoQ[$], refQ[$], expRx[$];
  bit halfA[0:255], halfB[0:255], expBits[0:255];
  logic expSd = 1'b0, expUnder = 1'b0;
  bit popPending = 0, sdPending = 0, sdNext = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference frame: expected serial stream, FIFO consumption and receive words
  task automatic buildFrame(input int frameBits);
    int idx = 0;
    for (int i = 0; i < frameBits; i++) begin
      halfA[i] = 1'($urandom);
      halfB[i] = 1'($urandom);
      expBits[i] = 0;
    end
    for (int s = 0; s < (twoSub ? 2 : 1); s++) begin
      int cnt = (s == 1) ? int'(chanCnt1) + 1 : int'(chanCnt0) + 1;
      int sl  = (s == 1) ? int'(slotLen1) : int'(slotLen0);
      int wl  = (s == 1) ? int'(wordLen1) : int'(wordLen0);
      logic [31:0] m = (s == 1) ? validMask1 : validMask0;
      for (int c = 0; c < cnt; c++) begin
        logic [31:0] w = 0;
        if (m[c] && txEn) begin
          if (refQ.size() > 0) w = refQ.pop_front();
          else expUnder = 1'b1;
          for (int b = 0; b < wl; b++) expBits[idx + b] = w[wl - 1 - b];
        end
        if (m[c] && rxEn) begin
          logic [31:0] r = 0;
          for (int b = 0; b < wl; b++)
            r = (r << 1) | 32'(sampleAtEnd ? halfB[idx + b] : halfA[idx + b]);
          expRx.push_back(r);
        end
        idx += sl;
      end
    end
  endtask

  task automatic step(input bit bs, input bit fs, input bit bm, input bit be, input bit sdi,
                      input bit newBit, input bit newVal);
    @(negedge clk);
    if (popPending) begin
      void'(fifoQ.pop_front());
      popPending = 0;
    end
    if (sdPending) begin
      expSd = sdNext;
      sdPending = 0;
    end
    chk(sdOut === expSd, "R3/R9 sdOut stream", 32'(sdOut), 32'(expSd));
    if (rxPush === 1'b1) begin
      if (expRx.size() == 0) chk(0, "R4/R7 unexpected rxPush", rxData, 0);
      else begin
        logic [31:0] e = expRx.pop_front();
        chk(rxData === e, "R5/R6 rxData", rxData, e);
      end
    end
    bitStart = bs; frameStart = fs; bitMid = bm; bitEnd = be; sdIn = sdi;
    txEmpty = (fifoQ.size() == 0);
    txData  = txEmpty ? 32'h0 : fifoQ[0];
    if (newBit) begin
      sdPending = 1;
      sdNext = newVal;
    end
    #1;
    popPending = (txPop === 1'b1);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    fifoQ.delete(); refQ.delete(); expRx.delete();
    expSd = 0; expUnder = 0; popPending = 0; sdPending = 0;
    bitStart = 0; frameStart = 0; bitMid = 0; bitEnd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runScenario(input string tag, input int frames, input int frameBits, input int words);
    doReset();
    for (int i = 0; i < words; i++) begin
      logic [31:0] w = $urandom;
      fifoQ.push_back(w);
      refQ.push_back(w);
    end
    for (int f = 0; f < frames; f++) begin
      buildFrame(frameBits);
      for (int k = 0; k < frameBits; k++) begin
        step(1, k == 0, 0, 0, halfA[k], 1, expBits[k]);
        step(0, 0, 1, 0, halfA[k], 0, 0);
        step(0, 0, 0, 0, halfB[k], 0, 0);
        step(0, 0, 0, 1, halfB[k], 0, 0);
      end
    end
    repeat (6) step(0, 0, 0, 0, 0, 0, 0);
    chk(txUnderrun === expUnder, {tag, " R8 underrun flag"}, 32'(txUnderrun), 32'(expUnder));
    chk(expRx.size() == 0, {tag, " R5 missing pushes"}, expRx.size(), 0);
    chk(fifoQ.size() == refQ.size(), {tag, " R4 FIFO words left"}, fifoQ.size(), refQ.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: outputs quiet in reset
    repeat (2) @(negedge clk);
    chk(sdOut === 1'b0, "R10 sdOut in reset", 32'(sdOut), 0);
    chk(rxPush === 1'b0, "R10 rxPush in reset", 32'(rxPush), 0);
    chk(txPop === 1'b0, "R10 txPop in reset", 32'(txPop), 0);
    chk(txUnderrun === 1'b0, "R10 txUnderrun in reset", 32'(txUnderrun), 0);

    // R2 R3 R6: one sub-frame, full words, centre sampling, both directions
    twoSub = 0; sampleAtEnd = 0; txEn = 1; rxEn = 1;
    chanCnt0 = 1; slotLen0 = 16; wordLen0 = 16; validMask0 = 32'h3;
    chanCnt1 = 3; slotLen1 = 9; wordLen1 = 9; validMask1 = 32'hF;
    runScenario("R2/R3", 3, 40, 6);

    // R1 R4 R8 R6: two sub-frames, masked slot, tail bits, end sampling, underrun
    twoSub = 1; sampleAtEnd = 1;
    chanCnt0 = 2; slotLen0 = 12; wordLen0 = 8;  validMask0 = 32'h5;
    chanCnt1 = 1; slotLen1 = 32; wordLen1 = 32; validMask1 = 32'h3;
    runScenario("R1/R8", 2, 110, 5);

    // R7 R4: transmit only, 7-bit words, sparse mask
    twoSub = 1; sampleAtEnd = 0; txEn = 1; rxEn = 0;
    chanCnt0 = 3; slotLen0 = 9;  wordLen0 = 7;  validMask0 = 32'hA;
    chanCnt1 = 0; slotLen1 = 20; wordLen1 = 13; validMask1 = 32'h1;
    runScenario("R7/R4", 2, 60, 10);

    // R7 R2: receive only, 32 channels, transmit FIFO must stay untouched
    twoSub = 0; sampleAtEnd = 0; txEn = 0; rxEn = 1;
    chanCnt0 = 31; slotLen0 = 7; wordLen0 = 7; validMask0 = 32'hF0F0_1234;
    runScenario("R7/R2", 1, 230, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule